// File: doc/BRIEF.md
# Packed-Write Colour Palette Loader

This block holds a 256-entry colour lookup table of 24-bit RGB values and loads it through a narrow indirect register interface. A host writes 32-bit words to one of four word ports: an address port, a colour-data port, a control port and an overlay-data port. Data words are split into 8-bit colour components. Three components make one entry, and they are applied red first, then green, then blue. An entry pointer advances by itself, so a host can set the address once and then stream any number of entries.

A mode input picks how a data word is consumed. In packed mode all four bytes are used, most significant byte first. The red/green/blue sequence therefore runs across entry boundaries inside one word. In top-byte mode only bits 31:24 count, and each write supplies a single component. The control port reaches two internal registers through the address register: a command register and a read mask. A pixel port ANDs an 8-bit index with the read mask and returns the selected entry one cycle later. A four-entry overlay table is loaded through the overlay port using the same sequencing, and it has its own lookup port.

Component sequencing is a three-state machine with the states PH_RED, PH_GREEN and PH_BLUE:
- Each consumed byte moves PH_RED to PH_GREEN, PH_GREEN to PH_BLUE, and PH_BLUE back to PH_RED. The step out of PH_BLUE commits the entry and advances the pointer.
- Any address write forces the state to PH_RED.

Top module: `pal_loader`

## Requirements
- R1: After reset the address pointer is 0, the component state is red, the read mask is 0xFF and the command register is 0x00. A first data write with no address write therefore loads entry 0.
- R2: Port select encoding on `wr_sel`: 0 is the address port, 1 is colour data, 2 is control, 3 is overlay data. Nothing is written while `wr_en` is low.
- R3: In packed mode (`top_byte_only`=0) a data write supplies four components, taken from bits 31:24, 23:16, 15:8 and 7:0 in that order. Starting at address 0, word 0x11223344 gives entry 0 = 0x112233 and leaves 0x44 as the red of entry 1.
- R4: In top-byte mode (`top_byte_only`=1) only bits 31:24 of each data, address or control write are used, and each data write supplies exactly one component. Bits 23:0 have no effect.
- R5: An entry becomes visible only when its blue component arrives, and all three components are written together at that point. The pointer then advances by one and wraps from 255 to 0. A partly loaded entry keeps its old value.
- R6: An address write loads the pointer from bits 7:0 in packed mode, or from bits 31:24 in top-byte mode. It returns the component state to red and discards any staged red or green.
- R7: A control write stores its byte (bits 7:0 in packed mode, bits 31:24 in top-byte mode) in the command register when the address is 0x06, or in the read mask when the address is 0x04. At any other address the control write changes neither register. Control writes leave the pointer and component state unchanged.
- R8: `pix_rgb` shows the entry at index (`pix_idx` AND read mask) one clock after `pix_idx` is presented, with red in bits 23:16 and blue in bits 7:0.
- R9: Overlay-port writes follow the same component sequence and the same shared pointer. The completed entry goes to overlay entry (pointer mod 4) and leaves the main table untouched. `ovl_rgb` shows overlay entry `ovl_sel` one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| top_byte_only | input | 1 | 1 selects top-byte mode, 0 selects packed mode |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Word port selected by the write |
| wr_data | input | 32 | Host write data |
| pix_idx | input | 8 | Pixel index for lookup |
| pix_rgb | output | 24 | Looked-up colour, one cycle latency |
| ovl_sel | input | 2 | Overlay entry to look up |
| ovl_rgb | output | 24 | Overlay colour, one cycle latency |
| cmd_reg | output | 8 | Command register value |
| read_mask | output | 8 | Read mask value |

## Verification
A component state that is off by one shifts every later colour by one byte. The fault shows up on `pix_rgb` at the next lookup of the entry that should have been completed, and the same wrong word also moves the commit point to a different entry. A pointer that is wrong or has lost its wrap puts correct colours at the wrong index, which a full sweep of the table exposes. A bad command register or read mask shows directly on its port one cycle after the control write. A bad read mask also alters which entry comes back for indices with upper bits set.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CMAP = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_OVL  = 2'd3
    } port_sel_e;

    localparam int CMD_SEL  = 6;
    localparam int MASK_SEL = 4;

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int CW    = 8,
    parameter int IDX_W = 8,
    localparam int LANES = BUS_W / CW,
    localparam int RGB_W = 3 * CW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [BUS_W-1:0]              wr_data,
    input  logic                          top_only,
    input  logic [CW-1:0]                 host_byte,
    output logic [IDX_W-1:0]              ptr_q,
    output logic                          cm_ovl,
    output logic [LANES-1:0]              cm_we,
    output logic [LANES-1:0][IDX_W-1:0]   cm_idx,
    output logic [LANES-1:0][RGB_W-1:0]   cm_rgb
);

    phase_e                 ph_q, ph_d;
    logic [IDX_W-1:0]       ptr_d;
    logic [CW-1:0]          r_q, r_d, g_q, g_d;
    logic [LANES-1:0][CW-1:0] lanes;
    logic                   addr_wr, data_wr;

    assign lanes   = wr_data;
    assign addr_wr = wr_en && (port_sel_e'(wr_sel) == SEL_ADDR);
    assign data_wr = wr_en && ((port_sel_e'(wr_sel) == SEL_CMAP) ||
                               (port_sel_e'(wr_sel) == SEL_OVL));
    assign cm_ovl  = wr_en && (port_sel_e'(wr_sel) == SEL_OVL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_RED;
            ptr_q <= '0;
            r_q   <= '0;
            g_q   <= '0;
        end else begin
            ph_q  <= ph_d;
            ptr_q <= ptr_d;
            r_q   <= r_d;
            g_q   <= g_d;
        end
    end

    // next state and commit outputs, walking the lanes MSB first
    always_comb begin
        ph_d   = ph_q;
        ptr_d  = ptr_q;
        r_d    = r_q;
        g_d    = g_q;
        cm_we  = '0;
        cm_idx = '0;
        cm_rgb = '0;
        if (addr_wr) begin
            ptr_d = IDX_W'(host_byte);
            ph_d  = PH_RED;
            r_d   = '0;
            g_d   = '0;
        end else if (data_wr) begin
            for (int k = 0; k < LANES; k++) begin
                if (k == 0 || !top_only) begin
                    unique case (ph_d)
                        PH_RED: begin
                            r_d  = lanes[LANES-1-k];
                            ph_d = PH_GREEN;
                        end
                        PH_GREEN: begin
                            g_d  = lanes[LANES-1-k];
                            ph_d = PH_BLUE;
                        end
                        PH_BLUE: begin
                            cm_we[k]  = 1'b1;
                            cm_idx[k] = ptr_d;
                            cm_rgb[k] = {r_d, g_d, lanes[LANES-1-k]};
                            ptr_d     = ptr_d + IDX_W'(1);
                            ph_d      = PH_RED;
                        end
                        default: ph_d = PH_RED;
                    endcase
                end
            end
        end
    end

    // R6
    addr_resets_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (ph_q == PH_RED));

    // R4
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_only |-> ($countones(cm_we) <= 1));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ptr_q));

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
#(
    parameter int CW    = 8,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [IDX_W-1:0] reg_addr,
    input  logic [CW-1:0]    value,
    output logic [CW-1:0]    cmd_q,
    output logic [CW-1:0]    mask_q
);

    logic hit_cmd, hit_mask;

    assign hit_cmd  = ctrl_wr && (reg_addr == IDX_W'(CMD_SEL));
    assign hit_mask = ctrl_wr && (reg_addr == IDX_W'(MASK_SEL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mask_q <= '1;
        end else begin
            if (hit_cmd)  cmd_q  <= value;
            if (hit_mask) mask_q <= value;
        end
    end

    // R7
    ctrl_other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_addr != IDX_W'(CMD_SEL) && reg_addr != IDX_W'(MASK_SEL))
        |=> ($stable(cmd_q) && $stable(mask_q)));

endmodule

// File: rtl/pal_table.sv
module pal_table #(
    parameter int ENTRIES = 256,
    parameter int LANES   = 4,
    parameter int RGB_W   = 24,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES-1:0]             we,
    input  logic [LANES-1:0][IDX_W-1:0]  widx,
    input  logic [LANES-1:0][RGB_W-1:0]  wrgb,
    input  logic [IDX_W-1:0]             rd_idx,
    input  logic [IDX_W-1:0]             rd_mask,
    output logic [RGB_W-1:0]             rd_rgb
);

    logic [RGB_W-1:0] mem [ENTRIES];
    logic [IDX_W-1:0] idx_m;

    assign idx_m = rd_idx & rd_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) mem[widx[l]] <= wrgb[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_rgb <= '0;
        else        rd_rgb <= mem[idx_m];
    end

    // R8
    lookup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) == '0 && $stable(idx_m)) |=> $stable(rd_rgb));

endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int CW      = 8,
    parameter int ENTRIES = 256,
    parameter int OVL_N   = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OIDX_W = $clog2(OVL_N),
    localparam int RGB_W  = 3 * CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              top_byte_only,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    input  logic [OIDX_W-1:0] ovl_sel,
    output logic [RGB_W-1:0]  ovl_rgb,
    output logic [CW-1:0]     cmd_reg,
    output logic [CW-1:0]     read_mask
);

    localparam int LANES = BUS_W / CW;

    logic [CW-1:0]                   host_byte;
    logic [IDX_W-1:0]                ptr;
    logic                            cm_ovl;
    logic [LANES-1:0]                cm_we, main_we, ovl_we;
    logic [LANES-1:0][IDX_W-1:0]     cm_idx;
    logic [LANES-1:0][OIDX_W-1:0]    ovl_idx;
    logic [LANES-1:0][RGB_W-1:0]     cm_rgb;
    logic                            ctrl_wr;

    assign host_byte = top_byte_only ? wr_data[BUS_W-1 -: CW] : wr_data[CW-1:0];
    assign ctrl_wr   = wr_en && (port_sel_e'(wr_sel) == SEL_CTRL);
    assign main_we   = cm_we & {LANES{!cm_ovl}};
    assign ovl_we    = cm_we & {LANES{cm_ovl}};

    for (genvar k = 0; k < LANES; k++) begin : g_ovl_idx
        assign ovl_idx[k] = cm_idx[k][OIDX_W-1:0];
    end

    pal_seq #(.BUS_W(BUS_W), .CW(CW), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .top_only(top_byte_only), .host_byte(host_byte),
        .ptr_q(ptr), .cm_ovl(cm_ovl), .cm_we(cm_we), .cm_idx(cm_idx),
        .cm_rgb(cm_rgb)
    );

    pal_ctrl #(.CW(CW), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .reg_addr(ptr),
        .value(host_byte), .cmd_q(cmd_reg), .mask_q(read_mask)
    );

    pal_table #(.ENTRIES(ENTRIES), .LANES(LANES), .RGB_W(RGB_W)) u_main (
        .clk(clk), .rst_n(rst_n), .we(main_we), .widx(cm_idx), .wrgb(cm_rgb),
        .rd_idx(pix_idx), .rd_mask(IDX_W'(read_mask)), .rd_rgb(pix_rgb)
    );

    pal_table #(.ENTRIES(OVL_N), .LANES(LANES), .RGB_W(RGB_W)) u_ovl (
        .clk(clk), .rst_n(rst_n), .we(ovl_we), .widx(ovl_idx), .wrgb(cm_rgb),
        .rd_idx(ovl_sel), .rd_mask({OIDX_W{1'b1}}), .rd_rgb(ovl_rgb)
    );

    // R9
    ovl_keeps_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_ovl |-> (main_we == '0));

endmodule

// File: tb/test_pal_loader.sv
`timescale 1ns/1ps
module test_pal_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        top_byte_only = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [7:0]  pix_idx = 8'd0;
    logic [23:0] pix_rgb;
    logic [1:0]  ovl_sel = 2'd0;
    logic [23:0] ovl_rgb;
    logic [7:0]  cmd_reg, read_mask;

    int total = 0;
    int bad = 0;

    // reference model state
    logic [23:0] m_tab [256];
    logic [23:0] m_ovl [4];
    int          m_ph;
    logic [7:0]  m_ptr, m_r, m_g, m_cmd, m_mask;

    always #4 clk = ~clk;

    pal_loader i_pal_loader (
        .clk(clk), .rst_n(rst_n), .top_byte_only(top_byte_only),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb), .ovl_sel(ovl_sel),
        .ovl_rgb(ovl_rgb), .cmd_reg(cmd_reg), .read_mask(read_mask)
    );

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_apply(input logic [1:0] sel, input logic [31:0] d, input logic top);
        logic [7:0] hb;
        logic [7:0] b;
        hb = top ? d[31:24] : d[7:0];
        case (sel)
            2'd0: begin m_ptr = hb; m_ph = 0; m_r = 8'd0; m_g = 8'd0; end
            2'd2: begin
                if (m_ptr == 8'h06) m_cmd = hb;
                else if (m_ptr == 8'h04) m_mask = hb;
            end
            default: begin
                for (int k = 0; k < (top ? 1 : 4); k++) begin
                    b = d[31-8*k -: 8];
                    if (m_ph == 0) begin m_r = b; m_ph = 1; end
                    else if (m_ph == 1) begin m_g = b; m_ph = 2; end
                    else begin
                        if (sel == 2'd1) m_tab[m_ptr] = {m_r, m_g, b};
                        else m_ovl[m_ptr[1:0]] = {m_r, m_g, b};
                        m_ptr = m_ptr + 8'd1;
                        m_ph = 0;
                    end
                end
            end
        endcase
    endtask

    task automatic drive(input logic [1:0] sel, input logic [31:0] d, input logic top);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; top_byte_only = top;
        model_apply(sel, d, top);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [7:0] idx, input logic [23:0] exp);
        @(negedge clk);
        wr_en = 1'b0;
        pix_idx = idx;
        @(negedge clk);
        chk(req, pix_rgb, exp);
    endtask

    task automatic look_ovl(input string req, input logic [1:0] idx, input logic [23:0] exp);
        @(negedge clk);
        wr_en = 1'b0;
        ovl_sel = idx;
        @(negedge clk);
        chk(req, ovl_rgb, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < 256; e++) m_tab[e] = 24'd0;
        for (int e = 0; e < 4; e++) m_ovl[e] = 24'd0;
        m_ph = 0; m_ptr = 8'd0; m_r = 8'd0; m_g = 8'd0; m_cmd = 8'h00; m_mask = 8'hFF;
        void'($urandom(32'h0C01_0A5E));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 cmd", {16'd0, cmd_reg}, 24'h000000);
        chk("R1 mask", {16'd0, read_mask}, 24'h0000FF);

        // R1 R3 packed words from reset, phase crosses entries
        drive(2'd1, 32'h11223344, 1'b0);
        look("R3 entry0", 8'd0, 24'h112233);
        look("R5 entry1 partial", 8'd1, 24'h000000);
        drive(2'd1, 32'h55667788, 1'b0);
        look("R3 entry1", 8'd1, 24'h445566);
        look("R5 entry2 partial", 8'd2, 24'h000000);
        drive(2'd1, 32'h99AABBCC, 1'b0);
        look("R3 entry2", 8'd2, 24'h778899);
        look("R3 entry3", 8'd3, 24'hAABBCC);

        // R4 top-byte mode
        drive(2'd0, 32'h05000000, 1'b1);
        drive(2'd1, 32'hA1FFFFFF, 1'b1);
        look("R4 one comp", 8'd5, 24'h000000);
        drive(2'd1, 32'hB2123456, 1'b1);
        drive(2'd1, 32'hC3ABCDEF, 1'b1);
        look("R4 entry5", 8'd5, 24'hA1B2C3);
        look("R4 low bytes ignored", 8'd6, 24'h000000);

        // R5 wrap 255 -> 0
        drive(2'd0, 32'h000000FF, 1'b0);
        drive(2'd1, 32'h01020304, 1'b0);
        look("R5 entry255", 8'd255, 24'h010203);
        look("R5 entry0 staged", 8'd0, 24'h112233);
        drive(2'd1, 32'h05060708, 1'b0);
        look("R5 wrapped entry0", 8'd0, 24'h040506);
        look("R5 entry1 staged", 8'd1, 24'h445566);

        // R6 address write discards staged red
        drive(2'd0, 32'h00000010, 1'b0);
        drive(2'd1, 32'hEE000000, 1'b1);
        drive(2'd0, 32'h00000010, 1'b0);
        drive(2'd1, 32'h11000000, 1'b1);
        drive(2'd1, 32'h22000000, 1'b1);
        drive(2'd1, 32'h33000000, 1'b1);
        look("R6 entry10", 8'h10, 24'h112233);

        // R7 control registers
        drive(2'd0, 32'h00000006, 1'b0);
        drive(2'd2, 32'h00000073, 1'b0);
        idle();
        chk("R7 cmd", {16'd0, cmd_reg}, 24'h000073);
        drive(2'd0, 32'h00000004, 1'b0);
        drive(2'd2, 32'h0000000F, 1'b0);
        idle();
        chk("R7 mask", {16'd0, read_mask}, 24'h00000F);
        drive(2'd0, 32'h00000005, 1'b0);
        drive(2'd2, 32'h00000055, 1'b0);
        idle();
        chk("R7 other cmd", {16'd0, cmd_reg}, 24'h000073);
        chk("R7 other mask", {16'd0, read_mask}, 24'h00000F);

        // R8 masked lookup
        look("R8 mask 15", 8'h15, 24'hA1B2C3);
        look("R8 mask F0", 8'hF0, 24'h040506);

        // R4 R7 control in top-byte mode
        drive(2'd0, 32'h06000000, 1'b1);
        drive(2'd2, 32'h70FFFFFF, 1'b1);
        idle();
        chk("R7 top cmd", {16'd0, cmd_reg}, 24'h000070);
        drive(2'd0, 32'h00000004, 1'b0);
        drive(2'd2, 32'h000000FF, 1'b0);
        idle();
        chk("R7 mask restore", {16'd0, read_mask}, 24'h0000FF);
        look("R8 full mask", 8'h15, 24'h000000);

        // R9 overlay port
        drive(2'd0, 32'h00000001, 1'b0);
        drive(2'd3, 32'h0A0B0C0D, 1'b0);
        look_ovl("R9 ovl1", 2'd1, 24'h0A0B0C);
        look("R9 main untouched", 8'd1, 24'h445566);
        drive(2'd3, 32'h0E0F1011, 1'b0);
        look_ovl("R9 ovl2", 2'd2, 24'h0D0E0F);

        // R2 random mix against the model
        for (int n = 0; n < 400; n++) begin
            int op;
            logic top;
            op  = $urandom % 10;
            top = (($urandom % 4) == 0);
            if (op == 0)      drive(2'd0, $urandom, top);
            else if (op < 7)  drive(2'd1, $urandom, top);
            else if (op == 7) drive(2'd3, $urandom, top);
            else if (op == 8) drive(2'd2, $urandom, top);
            else begin
                logic [7:0] ri;
                ri = 8'($urandom);
                look("R2 random lookup", ri, m_tab[ri & m_mask]);
            end
        end
        drive(2'd0, 32'h00000004, 1'b0);
        drive(2'd2, 32'h000000FF, 1'b0);
        idle();
        chk("R7 random mask", {16'd0, read_mask}, {16'd0, m_mask});
        chk("R7 random cmd", {16'd0, cmd_reg}, {16'd0, m_cmd});
        for (int e = 0; e < 256; e++) look("R3 sweep", 8'(e), m_tab[e]);
        for (int e = 0; e < 4; e++) look_ovl("R9 sweep", 2'(e), m_ovl[e]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule